// File: doc/BRIEF.md
# Dual-Pass Redundant SAR Conversion Sequencer

This block is the digital controller of a 14-step successive-approximation converter whose capacitor array uses redundant, non-binary weights (MSB to LSB: 1920, 1024, 544, 288, 144, 80, 40, 24, 12, 8, 6, 2, 2, 1, summing to 4095, a 12-bit range). It runs a free-running frame of 40 clock cycles. The first cycle returns every DAC switch to common mode, and the second tracks the input. Fourteen cycles then resolve a first raw word, and fourteen more resolve a second raw word from the same held input. The remaining cycles are idle.

A calibration-mode input, captured once per frame, decides whether a separate calibration capacitor injects a known offset. When it does, the offset is injected with positive sign during the first conversion and negative sign during the second. The digital back-end can then correlate the offset out of the two words. At each step the sequencer tentatively connects the current capacitor to the positive reference and samples the comparator. It keeps the bit when the input is above the DAC level and moves the capacitor to the negative reference otherwise. Both raw words are presented together with a one-cycle done strobe.

Top module: `sar_dual_seq`

## Requirements
- R1: The frame is 40 cycles long and repeats without gaps: cycle 0 is reset, cycle 1 is sample (`smp_on` high in that cycle only), cycles 2 to 15 are the first conversion, cycles 16 to 29 are the second, and cycles 30 to 39 are idle. Cycle 0 is the first cycle after reset is released.
- R2: Outside the 28 conversion cycles, every capacitor sits at common mode (`dac_p` and `dac_n` all zero).
- R3: In step s (0 to 13) of either conversion, bit 13-s has `dac_p`=1 and `dac_n`=0, and every lower bit is at common mode. No bit ever has `dac_p` and `dac_n` both set. The second conversion starts from a clean array.
- R4: A high `cmp_hi` at the end of a step records raw bit 1 and leaves that capacitor on the positive reference for the rest of the conversion. A low `cmp_hi` records 0 and moves the capacitor to the negative reference. Raw bit 13 is the first decision.
- R5: With the frame's mode set, `inj_pos` is high for exactly the first-conversion cycles and `inj_neg` is high for exactly the second-conversion cycles. With the mode clear, both stay low. The two are never high together.
- R6: `cal_mode` is captured at the end of the reset cycle. Changes during the rest of the frame have no effect on injection or results.
- R7: `word_a` (first conversion) and `word_b` (second conversion) are updated together at the edge that ends cycle 29. Both hold their values at every other edge.
- R8: `done` is high for the single cycle 30 of each frame.
- R9: Asynchronous active-low `rst_n` clears both words, `done`, the injection controls and the DAC controls. After release, a new frame starts at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 1 | 1 = inject calibration offset this frame |
| cmp_hi | input | 1 | Comparator: input above current DAC level |
| smp_on | output | 1 | Input sampling switch closed |
| dac_p | output | 14 | Per-capacitor switch to positive reference |
| dac_n | output | 14 | Per-capacitor switch to negative reference |
| inj_pos | output | 1 | Calibration capacitor, positive offset |
| inj_neg | output | 1 | Calibration capacitor, negative offset |
| word_a | output | 14 | Raw bits of the first conversion |
| word_b | output | 14 | Raw bits of the second conversion |
| done | output | 1 | One-cycle strobe, both words valid |

## Verification
The bench drives full-scale, zero and just-above/just-below-MSB inputs (1920 and 1919), which would expose a keep-on-equal error or a swapped bit order through wrong raw words. With injection enabled, inputs near the top and bottom make the first pass saturate to all ones and the second to all zeros. A design with the polarity swapped, or with injection tied to the wrong pass, returns the words exchanged. Toggling `cal_mode` mid-frame catches a design that follows the pin instead of a per-frame capture. A reset in the middle of the second conversion catches stale decisions or a frame counter that does not restart.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        PH_RESET,
        PH_SAMPLE,
        PH_CONV_A,
        PH_CONV_B,
        PH_IDLE
    } sar_phase_e;

endpackage

// File: rtl/sar_phase_decode.sv
module sar_phase_decode
    import sar_pkg::*;
#(
    parameter int NBITS     = 14,
    parameter int FRAME_CYC = 40,
    parameter int CW        = $clog2(FRAME_CYC),
    parameter int SW        = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic [CW-1:0] cnt,
    output sar_phase_e    phase,
    output logic [SW-1:0] bit_idx,
    output logic          last_step,
    output logic          frame_end
);
    localparam logic [CW-1:0] C_SMP   = CW'(1);
    localparam logic [CW-1:0] C_A0    = CW'(2);
    localparam logic [CW-1:0] C_B0    = CW'(2 + NBITS);
    localparam logic [CW-1:0] C_IDLE0 = CW'(2 + 2 * NBITS);
    localparam logic [CW-1:0] C_LAST  = CW'(FRAME_CYC - 1);
    localparam logic [SW-1:0] TOP_BIT = SW'(NBITS - 1);

    logic [CW-1:0] step;

    always_comb begin
        phase = PH_IDLE;
        step  = '0;
        if (cnt == '0) begin
            phase = PH_RESET;
        end else if (cnt == C_SMP) begin
            phase = PH_SAMPLE;
        end else if (cnt < C_B0) begin
            phase = PH_CONV_A;
            step  = cnt - C_A0;
        end else if (cnt < C_IDLE0) begin
            phase = PH_CONV_B;
            step  = cnt - C_B0;
        end
        bit_idx   = TOP_BIT - SW'(step);
        last_step = (cnt == C_B0 - CW'(1)) || (cnt == C_IDLE0 - CW'(1));
        frame_end = (cnt == C_LAST);
    end

endmodule

// File: rtl/sar_dac_drive.sv
module sar_dac_drive #(
    parameter int NBITS = 14,
    parameter int SW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             active,
    input  logic [SW-1:0]    bit_idx,
    input  logic [NBITS-1:0] dec,
    output logic [NBITS-1:0] dac_p,
    output logic [NBITS-1:0] dac_n
);
    for (genvar i = 0; i < NBITS; i++) begin : g_cap
        logic above;
        logic cur;
        assign above    = active && (SW'(i) > bit_idx);
        assign cur      = active && (SW'(i) == bit_idx);
        assign dac_p[i] = cur | (above & dec[i]);
        assign dac_n[i] = above & ~dec[i];
    end

endmodule

// File: rtl/sar_dual_seq.sv
module sar_dual_seq
    import sar_pkg::*;
#(
    parameter int NBITS     = 14,
    parameter int FRAME_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_mode,
    input  logic             cmp_hi,
    output logic             smp_on,
    output logic [NBITS-1:0] dac_p,
    output logic [NBITS-1:0] dac_n,
    output logic             inj_pos,
    output logic             inj_neg,
    output logic [NBITS-1:0] word_a,
    output logic [NBITS-1:0] word_b,
    output logic             done
);
    localparam int CW = $clog2(FRAME_CYC);
    localparam int SW = (NBITS > 1) ? $clog2(NBITS) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             mode;
        logic [NBITS-1:0] dec;
        logic [NBITS-1:0] hold_a;
        logic [NBITS-1:0] wa;
        logic [NBITS-1:0] wb;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;

    sar_phase_e    phase;
    logic [SW-1:0] bit_idx;
    logic          last_step;
    logic          frame_end;
    logic          converting;
    logic [NBITS-1:0] dec_upd;

    sar_phase_decode #(
        .NBITS(NBITS), .FRAME_CYC(FRAME_CYC), .CW(CW), .SW(SW)
    ) u_phase (
        .cnt(st_q.cnt), .phase(phase), .bit_idx(bit_idx),
        .last_step(last_step), .frame_end(frame_end)
    );

    assign converting = (phase == PH_CONV_A) || (phase == PH_CONV_B);

    sar_dac_drive #(.NBITS(NBITS), .SW(SW)) u_dac (
        .active(converting), .bit_idx(bit_idx), .dec(st_q.dec),
        .dac_p(dac_p), .dac_n(dac_n)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.cnt  = frame_end ? '0 : st_q.cnt + CW'(1);

        dec_upd          = st_q.dec;
        dec_upd[bit_idx] = cmp_hi;

        if (phase == PH_RESET) begin
            st_d.mode = cal_mode;
        end
        if (converting) begin
            st_d.dec = dec_upd;
        end
        if (phase == PH_CONV_A && last_step) begin
            st_d.hold_a = dec_upd;
        end
        if (phase == PH_CONV_B && last_step) begin
            st_d.wa   = st_q.hold_a;
            st_d.wb   = dec_upd;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_on  = (phase == PH_SAMPLE);
    assign inj_pos = st_q.mode && (phase == PH_CONV_A);
    assign inj_neg = st_q.mode && (phase == PH_CONV_B);
    assign word_a  = st_q.wa;
    assign word_b  = st_q.wb;
    assign done    = st_q.done;

endmodule

// File: rtl/sar_dual_seq_chk.sv
module sar_dual_seq_chk
    import sar_pkg::*;
#(
    parameter int NBITS = 14
) (
    input logic             clk,
    input logic             rst_n,
    input sar_phase_e       phase,
    input logic             smp_on,
    input logic [NBITS-1:0] dac_p,
    input logic [NBITS-1:0] dac_n,
    input logic             inj_pos,
    input logic             inj_neg,
    input logic [NBITS-1:0] word_a,
    input logic [NBITS-1:0] word_b,
    input logic             done
);
    // R1: sampling lasts a single cycle
    a_r1_smp_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp_on |=> !smp_on);

    // R3: no capacitor is driven to both references
    a_r3_no_short: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_p & dac_n) == '0);

    // R4: within one conversion a cleared bit stays cleared
    a_r4_clear_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == $past(phase) && (phase == PH_CONV_A || phase == PH_CONV_B))
        |-> (($past(dac_n) & ~dac_n) == '0));

    // R5: offset polarities are exclusive
    a_r5_inj_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(inj_pos && inj_neg));

    // R7: words move only together with the strobe
    a_r7_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(word_a) && $stable(word_b)));

    // R8: done is a single-cycle pulse during idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE && dac_p == '0 && dac_n == '0));

endmodule

bind sar_dual_seq sar_dual_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .smp_on(smp_on),
    .dac_p(dac_p), .dac_n(dac_n), .inj_pos(inj_pos), .inj_neg(inj_neg),
    .word_a(word_a), .word_b(word_b), .done(done)
);

// File: tb/tb_sar_dual_seq.sv
module tb_sar_dual_seq;
    localparam int NB   = 14;
    localparam int FL   = 40;
    localparam int CAL  = 37;
    localparam int WD   = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_mode = 1'b0;
    logic          cmp_hi;
    logic          smp_on, inj_pos, inj_neg, done;
    logic [NB-1:0] dac_p, dac_n, word_a, word_b;

    int errors = 0;
    int checks = 0;
    int vin = 0;
    bit cur_mode = 1'b0;
    int pos = 0;
    int wgt [NB] = '{1920, 1024, 544, 288, 144, 80, 40, 24, 12, 8, 6, 2, 2, 1};
    logic [2*NB-1:0] expq [$];

    sar_dual_seq dut (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .cmp_hi(cmp_hi),
        .smp_on(smp_on), .dac_p(dac_p), .dac_n(dac_n),
        .inj_pos(inj_pos), .inj_neg(inj_neg),
        .word_a(word_a), .word_b(word_b), .done(done)
    );

    always #10 clk = ~clk;

    // Behavioural comparator: weights of capacitors on the positive reference
    always_comb begin
        int lvl;
        int eff;
        lvl = 0;
        for (int i = 0; i < NB; i++) if (dac_p[i]) lvl += wgt[NB-1-i];
        eff = vin + (inj_pos ? CAL : 0) - (inj_neg ? CAL : 0);
        cmp_hi = (eff >= lvl);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos <= 0;
        else pos <= (pos == FL - 1) ? 0 : pos + 1;
    end

    function automatic logic [NB-1:0] expect_word(int eff);
        logic [NB-1:0] w;
        int acc;
        w = '0;
        acc = 0;
        for (int k = 0; k < NB; k++) begin
            if (eff >= acc + wgt[k]) begin
                w[NB-1-k] = 1'b1;
                acc += wgt[k];
            end
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (pos %0d)", tag, act, exp_v, pos);
        end
    endtask

    // Driver: one frame per call, expected words pushed to the scoreboard
    task automatic run_frame(input int v, input bit m, input bit flip_mid);
        logic [NB-1:0] ea, eb;
        while (pos != 0) @(negedge clk);
        vin = v;
        cal_mode = m;
        cur_mode = m;
        ea = expect_word(m ? v + CAL : v);
        eb = expect_word(m ? v - CAL : v);
        expq.push_back({ea, eb});
        if (flip_mid) begin
            while (pos != 10) @(negedge clk);
            cal_mode = ~m;  // R6: must not matter
        end
        while (pos != FL - 1) @(negedge clk);
    endtask

    // Monitor: frame structure every cycle, words on the strobe
    always @(negedge clk) begin
        if (rst_n) begin
            bit conv;
            conv = (pos >= 2 && pos < 2 + 2 * NB);
            chk(smp_on == (pos == 1), "R1 smp_on", smp_on, pos == 1);
            if (!conv) begin
                chk(dac_p == '0 && dac_n == '0, "R2 dac at common mode", {dac_p, dac_n}, 0);
            end else begin
                int s;
                int bi;
                logic [NB-1:0] lowm;
                s = (pos - 2) % NB;
                bi = NB - 1 - s;
                lowm = NB'((1 << bi) - 1);
                chk(dac_p[bi] && !dac_n[bi], "R3 trial bit", {dac_p[bi], dac_n[bi]}, 2);
                chk(((dac_p | dac_n) & lowm) == '0, "R3 lower bits common mode",
                    (dac_p | dac_n) & lowm, 0);
            end
            chk(inj_pos == (cur_mode && pos >= 2 && pos < 2 + NB), "R5 inj_pos",
                inj_pos, cur_mode && pos >= 2 && pos < 2 + NB);
            chk(inj_neg == (cur_mode && pos >= 2 + NB && pos < 2 + 2 * NB), "R5 inj_neg",
                inj_neg, cur_mode && pos >= 2 + NB && pos < 2 + 2 * NB);
            chk(done == (pos == 2 + 2 * NB), "R8 done timing", done, pos == 2 + 2 * NB);
            if (done) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 unexpected result", {word_a, word_b}, 0);
                end else begin
                    logic [2*NB-1:0] e;
                    e = expq.pop_front();
                    chk(word_a == e[2*NB-1:NB], "R4/R7 word_a", word_a, e[2*NB-1:NB]);
                    chk(word_b == e[NB-1:0], "R4/R7 word_b", word_b, e[NB-1:0]);
                end
            end
        end
    end

    initial begin
        #(WD * 20);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(word_a == '0 && word_b == '0 && !done, "R9 reset words", {word_a, word_b}, 0);
        chk(dac_p == '0 && dac_n == '0 && !inj_pos && !inj_neg, "R9 reset controls",
            {dac_p, dac_n}, 0);
        rst_n = 1'b1;

        run_frame(0, 0, 0);
        run_frame(4095, 0, 0);
        run_frame(1920, 0, 0);   // R4 equal keeps MSB
        run_frame(1919, 0, 0);
        run_frame(2048, 0, 0);
        run_frame(1000, 1, 0);   // R5
        run_frame(3000, 1, 0);
        run_frame(4080, 1, 0);   // first pass saturates
        run_frame(20, 1, 0);     // second pass floors
        run_frame(2500, 1, 1);   // R6 mode dropped mid-frame
        run_frame(777, 0, 1);    // R6 mode raised mid-frame
        seed = 12345;
        for (int n = 0; n < 20; n++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            run_frame((seed >> 8) % 4096, n[0], 0);
        end

        // R9: reset during second conversion
        while (pos != 0) @(negedge clk);
        vin = 1500;
        cal_mode = 1'b1;
        cur_mode = 1'b1;
        while (pos != 20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(word_a == '0 && word_b == '0 && !done, "R9 mid-frame reset words",
            {word_a, word_b}, 0);
        chk(dac_p == '0 && dac_n == '0 && !inj_pos && !inj_neg && !smp_on,
            "R9 mid-frame reset controls", {dac_p, dac_n}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(1234, 1, 0);
        run_frame(3333, 0, 0);
        @(negedge clk);
        chk(expq.size() == 0, "R7 all results delivered", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule